// File: doc/BRIEF.md
# Dual Countdown Timer Unit

This block holds two independent 8-bit down-counters, each driving its own interrupt line. The first timer is one-shot. Software writes a start value, and the timer steps down on one of two prescaler pulses: the fast one at a quarter of the system clock, or the slow one at 1/1024 of it. When the count passes from one to zero, the timer stops and raises its flag. It waits there until software writes it again.

The second timer runs freely while it is enabled. It keeps a preload value in a register of its own. When a step would take the count from one to zero, it puts the preload back into the counter on that same clock and raises its flag. It steps on either the fast prescaler pulse or the rising edges of an asynchronous event pin. The event pin passes through a synchronizer chain before its edges are detected.

A single write port handles everything:

| Address | Effect of a write |
|---------|-------------------|
| 0 | Loads the one-shot counter |
| 1 | Loads the preload register and the auto-reload counter together |
| 2 | Writes the mode bits |
| 3 | Clears interrupt flags, one bit per timer |

Both counts are visible at the ports at all times.

The one-shot timer's state machine has two states:
- `T0_IDLE`: a nonzero load moves it to `T0_RUN`; a zero load leaves it in `T0_IDLE`.
- `T0_RUN`: the expiring step returns it to `T0_IDLE`.

The auto-reload timer's state machine also has two states:
- `T1_OFF`: a mode write with the enable bit at 1 moves it to `T1_RUN`.
- `T1_RUN`: a mode write with the enable bit at 0 returns it to `T1_OFF`.

Top module: `tmr_pair_unit`

## Requirements
- R1: After reset, both counts read 0 and both interrupt outputs are 0. All mode bits are 0: the one-shot timer uses the fast pulse, and the auto-reload timer is disabled and uses its internal source.
- R2: A write to address 0 loads the one-shot counter with the data. A nonzero value starts the timer. A zero value leaves it idle at 0 and raises no flag.
- R3: A running one-shot timer decrements by one on each clock where its selected pulse is high. Mode bit 0 picks the pulse: 0 selects `tick_fast_i`, 1 selects `tick_slow_i`. The other pulse has no effect on the count.
- R4: When a one-shot step takes the count from 1 to 0, the timer sets its flag and stops. Later pulses leave the count at 0.
- R5: A write to address 1 sets both the preload and the auto-reload count to the data. On a clock where this write coincides with a step, the write wins and no flag is raised.
- R6: Mode bit 2 enables the auto-reload timer. While it is disabled, its count holds.
- R7: When an enabled auto-reload timer steps from a count of 1, it loads the preload and sets its flag on that clock. On any other step it decrements. A count of 0 wraps to 0xFF, so a preload of 0 gives a period of 256 steps.
- R8: With mode bit 1 set, the auto-reload timer steps on rising edges of `evt_pin_i`. A level first sampled at clock edge k changes the count at edge k+2, and `tick_fast_i` is then ignored. With mode bit 1 clear, the timer steps on `tick_fast_i`.
- R9: Each interrupt output stays high until a write to address 3 carries a 1 in that timer's bit: bit 0 for the one-shot timer, bit 1 for the auto-reload timer. A 0 in that bit leaves the flag as it is.
- R10: When a flag clear and an expiry of the same timer fall on the same clock, the flag ends up set.
- R11: A write to address 0 on a clock where the one-shot timer's pulse is also high loads the written value; the pulse is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address of the write |
| wr_data_i | input | CNT_W | Write data |
| tick_fast_i | input | 1 | Prescaler pulse at a quarter of the system clock |
| tick_slow_i | input | 1 | Prescaler pulse at 1/1024 of the system clock |
| evt_pin_i | input | 1 | Asynchronous external event pin |
| t0_count_o | output | CNT_W | One-shot timer count |
| t1_count_o | output | CNT_W | Auto-reload timer count |
| t0_irq_o | output | 1 | One-shot timer interrupt flag |
| t1_irq_o | output | 1 | Auto-reload timer interrupt flag |

## Verification
The bench builds the block with its default values: 8-bit counters and a two-flop synchronizer. With these values, a full 256-step wrap from a zero preload fits in a short run, and the two-cycle pin-to-count latency can be compared against the reference model edge by edge. Prescaler pulses are driven directly rather than at true rates. This puts the collisions within reach: a load meeting a step, a clear meeting an expiry, and the unselected pulse arriving while a timer runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {T0_IDLE, T0_RUN} t0_state_e;
    typedef enum logic {T1_OFF, T1_RUN} t1_state_e;

    localparam logic [1:0] ADDR_T0  = 2'd0;
    localparam logic [1:0] ADDR_T1  = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;
    localparam logic [1:0] ADDR_CLR = 2'd3;

    localparam int CTL_SLOW_BIT = 0;
    localparam int CTL_EXT_BIT  = 1;
    localparam int CTL_EN_BIT   = 2;
    localparam int CLR_T0_BIT   = 0;
    localparam int CLR_T1_BIT   = 1;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    for (genvar g = 0; g <= LAST; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // chain_q[LAST] is the delayed copy used only for edge detection
    assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/tmr_oneshot.sv
module tmr_oneshot
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    t0_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, expire;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
            st_d  = (load_val_i != ZERO) ? T0_RUN : T0_IDLE;
        end else begin
            unique case (st_q)
                T0_IDLE: ;
                T0_RUN: begin
                    if (tick_i) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            st_d   = T0_IDLE;
                            expire = 1'b1;
                        end
                    end
                end
                default: st_d = T0_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T0_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= ZERO;
            flag_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (expire)     flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign count_o = cnt_q;
    assign flag_o  = flag_q;
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             step_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] preload_o,
    output logic             run_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    t1_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, pre_q;
    logic             flag_q, expire;

    always_comb begin
        st_d = st_q;
        if (en_wr_i) st_d = en_val_i ? T1_RUN : T1_OFF;
    end

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else begin
            unique case (st_q)
                T1_OFF: ;
                T1_RUN: begin
                    if (step_i) begin
                        if (cnt_q == ONE) begin
                            cnt_d  = pre_q;
                            expire = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T1_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= ZERO;
            pre_q  <= ZERO;
            flag_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (load_i) pre_q <= load_val_i;
            if (expire)     flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign count_o   = cnt_q;
    assign preload_o = pre_q;
    assign run_o     = (st_q == T1_RUN);
    assign flag_o    = flag_q;
endmodule

// File: rtl/tmr_pair_unit.sv
module tmr_pair_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             tick_fast_i,
    input  logic             tick_slow_i,
    input  logic             evt_pin_i,
    output logic [CNT_W-1:0] t0_count_o,
    output logic [CNT_W-1:0] t1_count_o,
    output logic             t0_irq_o,
    output logic             t1_irq_o
);
    logic             wr_t0, wr_t1, wr_ctl, wr_clr;
    logic             sel_slow_q, ext_q;
    logic             t0_tick, t1_step, evt_rise;
    logic             t1_run;
    logic [CNT_W-1:0] t1_pre;

    assign wr_t0  = wr_en_i && (wr_addr_i == ADDR_T0);
    assign wr_t1  = wr_en_i && (wr_addr_i == ADDR_T1);
    assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTL);
    assign wr_clr = wr_en_i && (wr_addr_i == ADDR_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_slow_q <= 1'b0;
            ext_q      <= 1'b0;
        end else if (wr_ctl) begin
            sel_slow_q <= wr_data_i[CTL_SLOW_BIT];
            ext_q      <= wr_data_i[CTL_EXT_BIT];
        end
    end

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (evt_pin_i),
        .rise_o (evt_rise)
    );

    assign t0_tick = sel_slow_q ? tick_slow_i : tick_fast_i;
    assign t1_step = ext_q ? evt_rise : tick_fast_i;

    tmr_oneshot #(.CNT_W(CNT_W)) u_t0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_t0),
        .load_val_i (wr_data_i),
        .tick_i     (t0_tick),
        .clr_i      (wr_clr && wr_data_i[CLR_T0_BIT]),
        .count_o    (t0_count_o),
        .flag_o     (t0_irq_o)
    );

    tmr_reload #(.CNT_W(CNT_W)) u_t1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_t1),
        .load_val_i (wr_data_i),
        .en_wr_i    (wr_ctl),
        .en_val_i   (wr_data_i[CTL_EN_BIT]),
        .step_i     (t1_step),
        .clr_i      (wr_clr && wr_data_i[CLR_T1_BIT]),
        .count_o    (t1_count_o),
        .preload_o  (t1_pre),
        .run_o      (t1_run),
        .flag_o     (t1_irq_o)
    );
endmodule

// File: rtl/tmr_pair_checker.sv
module tmr_pair_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             tick_fast,
    input logic             tick_slow,
    input logic [CNT_W-1:0] t0_count,
    input logic [CNT_W-1:0] t1_count,
    input logic             t0_irq,
    input logic             t1_irq,
    input logic             t1_run,
    input logic             t1_ext,
    input logic [CNT_W-1:0] t1_pre
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic wr0, wr1, clr0, clr1;
    assign wr0  = wr_en && (wr_addr == 2'd0);
    assign wr1  = wr_en && (wr_addr == 2'd1);
    assign clr0 = wr_en && (wr_addr == 2'd3) && wr_data[0];
    assign clr1 = wr_en && (wr_addr == 2'd3) && wr_data[1];

    // R3: no pulse and no write leaves the one-shot count unchanged
    a_r3_t0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick_fast && !tick_slow) |=> $stable(t0_count));

    // R4: without a load the one-shot count never rises
    a_r4_t0_never_up: assert property (@(posedge clk) disable iff (!rst_n)
        !wr0 |=> (t0_count <= $past(t0_count)));

    // R10: expiry sets the flag whatever clear arrives with it
    a_r10_t0_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_count == ONE && tick_fast && tick_slow && !wr0) |=> (t0_irq && t0_count == '0));

    // R9: flags are sticky without a clear
    a_r9_t0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_irq && !clr0) |=> t0_irq);
    a_r9_t1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_irq && !clr1) |=> t1_irq);

    // R6: disabled auto-reload timer holds its count
    a_r6_t1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!t1_run && !wr1) |=> $stable(t1_count));

    // R7: reload from the preload with the flag raised
    a_r7_t1_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_run && !t1_ext && tick_fast && t1_count == ONE && !wr1)
        |=> (t1_irq && t1_count == $past(t1_pre)));

    // R5: a preload write lands in the count whatever the step does
    a_r5_t1_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr1 |=> (t1_count == $past(wr_data) && t1_pre == $past(wr_data)));
endmodule

bind tmr_pair_unit tmr_pair_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .tick_fast (tick_fast_i),
    .tick_slow (tick_slow_i),
    .t0_count  (t0_count_o),
    .t1_count  (t1_count_o),
    .t0_irq    (t0_irq_o),
    .t1_irq    (t1_irq_o),
    .t1_run    (t1_run),
    .t1_ext    (ext_q),
    .t1_pre    (t1_pre)
);

// File: tb/tmr_pair_unit_test.sv
`timescale 1ns/1ps
module tmr_pair_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic       tick_fast_i = 1'b0;
    logic       tick_slow_i = 1'b0;
    logic       evt_pin_i = 1'b0;
    logic [7:0] t0_count_o, t1_count_o;
    logic       t0_irq_o, t1_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_pair_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i),
        .evt_pin_i(evt_pin_i), .t0_count_o(t0_count_o), .t1_count_o(t1_count_o),
        .t0_irq_o(t0_irq_o), .t1_irq_o(t1_irq_o)
    );

    // behavioural reference model
    int m_c0 = 0, m_c1 = 0, m_pre = 0;
    bit m_run0 = 0, m_en = 0, m_f0 = 0, m_f1 = 0, m_slow = 0, m_ext = 0;
    bit pin_hist[$] = '{0, 0, 0};
    bit t0t, st1, rise, set0, set1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c0 = 0; m_c1 = 0; m_pre = 0; m_run0 = 0; m_en = 0;
            m_f0 = 0; m_f1 = 0; m_slow = 0; m_ext = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            rise = pin_hist[1] && !pin_hist[2];
            pin_hist.push_front(evt_pin_i);
            void'(pin_hist.pop_back());
            t0t  = m_slow ? tick_slow_i : tick_fast_i;
            st1  = m_ext ? rise : tick_fast_i;
            set0 = 0; set1 = 0;
            if (wr_en_i && wr_addr_i == 0) begin
                m_c0 = wr_data_i; m_run0 = (wr_data_i != 0);
            end else if (m_run0 && t0t) begin
                if (m_c0 == 1) begin m_c0 = 0; m_run0 = 0; set0 = 1; end
                else m_c0 = m_c0 - 1;
            end
            if (wr_en_i && wr_addr_i == 1) begin
                m_pre = wr_data_i; m_c1 = wr_data_i;
            end else if (m_en && st1) begin
                if (m_c1 == 1) begin m_c1 = m_pre; set1 = 1; end
                else m_c1 = (m_c1 + 255) % 256;
            end
            if (set0) m_f0 = 1;
            else if (wr_en_i && wr_addr_i == 3 && wr_data_i[0]) m_f0 = 0;
            if (set1) m_f1 = 1;
            else if (wr_en_i && wr_addr_i == 3 && wr_data_i[1]) m_f1 = 0;
            if (wr_en_i && wr_addr_i == 2) begin
                m_slow = wr_data_i[0]; m_ext = wr_data_i[1]; m_en = wr_data_i[2];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 t0 count model", t0_count_o, m_c0);
            chk("R4 t0 flag model", t0_irq_o, m_f0);
            chk("R7 t1 count model", t1_count_o, m_c1);
            chk("R9 t1 flag model", t1_irq_o, m_f1);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = 2'(a); wr_data_i = 8'(d);
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic fast(input int n);
        @(negedge clk);
        tick_fast_i = 1;
        repeat (n) @(negedge clk);
        tick_fast_i = 0;
    endtask

    task automatic slow(input int n);
        @(negedge clk);
        tick_slow_i = 1;
        repeat (n) @(negedge clk);
        tick_slow_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 t0 count reset", t0_count_o, 0);
        chk("R1 t1 count reset", t1_count_o, 0);
        chk("R1 t0 irq reset", t0_irq_o, 0);
        chk("R1 t1 irq reset", t1_irq_o, 0);
        rst_n = 1;

        // R3/R4: one-shot on fast pulse
        wr(0, 5);
        fast(4);
        chk("R3 t0 after 4 fast", t0_count_o, 1);
        fast(1);
        chk("R4 t0 expired", t0_count_o, 0);
        chk("R4 t0 flag", t0_irq_o, 1);
        fast(3);
        chk("R4 t0 stays stopped", t0_count_o, 0);

        // R9: clear semantics
        wr(3, 2);
        chk("R9 t0 flag kept by other bit", t0_irq_o, 1);
        wr(3, 1);
        chk("R9 t0 flag cleared", t0_irq_o, 0);

        // R3: slow select, fast ignored
        wr(2, 1);
        wr(0, 3);
        fast(5);
        chk("R3 fast ignored in slow mode", t0_count_o, 3);
        slow(1);
        chk("R3 slow step", t0_count_o, 2);

        // R11: load beats pulse
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = 0; wr_data_i = 9; tick_slow_i = 1;
        @(negedge clk);
        wr_en_i = 0; tick_slow_i = 0;
        chk("R11 load wins", t0_count_o, 9);

        // R10: clear with expiry
        wr(0, 1);
        slow(1);
        chk("R4 flag before collision", t0_irq_o, 1);
        wr(0, 1);
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = 3; wr_data_i = 1; tick_slow_i = 1;
        @(negedge clk);
        wr_en_i = 0; tick_slow_i = 0;
        chk("R10 set wins over clear", t0_irq_o, 1);
        wr(3, 1);

        // R2: zero load idles, no flag
        wr(0, 0);
        slow(2);
        chk("R2 zero load count", t0_count_o, 0);
        chk("R2 zero load no flag", t0_irq_o, 0);

        // R6/R7: auto-reload internal
        wr(1, 3);
        fast(2);
        chk("R6 disabled holds", t1_count_o, 3);
        wr(2, 4);
        fast(3);
        chk("R7 reloaded", t1_count_o, 3);
        chk("R7 flag", t1_irq_o, 1);
        wr(2, 0);
        fast(5);
        chk("R6 hold after disable", t1_count_o, 3);
        wr(3, 2);
        chk("R9 t1 cleared", t1_irq_o, 0);

        // R7 wrap with zero preload
        wr(1, 0);
        wr(2, 4);
        fast(1);
        chk("R7 wrap to FF", t1_count_o, 255);
        fast(254);
        chk("R7 down to 1", t1_count_o, 1);
        chk("R7 no flag yet", t1_irq_o, 0);
        fast(1);
        chk("R7 reload zero", t1_count_o, 0);
        chk("R7 flag on wrap period", t1_irq_o, 1);

        // R5: write beats step
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = 1; wr_data_i = 7; tick_fast_i = 1;
        @(negedge clk);
        wr_en_i = 0; tick_fast_i = 0;
        chk("R5 write wins", t1_count_o, 7);

        // R8: external events
        wr(2, 6);
        wr(1, 10);
        fast(5);
        chk("R8 fast ignored in ext", t1_count_o, 10);
        evt_pin_i = 1;
        @(negedge clk);
        chk("R8 not yet", t1_count_o, 10);
        @(negedge clk);
        chk("R8 latency", t1_count_o, 10);
        @(negedge clk);
        chk("R8 one edge", t1_count_o, 9);
        repeat (4) @(negedge clk);
        chk("R8 level no step", t1_count_o, 9);
        evt_pin_i = 0;
        repeat (3) @(negedge clk);
        evt_pin_i = 1;
        repeat (4) @(negedge clk);
        chk("R8 second edge", t1_count_o, 8);
        wr(2, 4);
        fast(2);
        chk("R8 back to internal", t1_count_o, 6);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule